// File: doc/BRIEF.md
# I2C Interrupt Flag and Clock-Hold Controller

This block keeps the three interrupt request flags of an I2C peripheral: a data flag for buffer-level events, an end-of-transfer flag and a protocol-event flag. It maps them onto two interrupt lines. The data line carries the OR of the data flag and the end-of-transfer flag. The protocol line carries the protocol-event flag alone. While any flag is pending and the peripheral either owns the bus as master or has been addressed as a slave, the block asks the pad to pull SCL low. This stretches the clock until software has serviced the request.

The byte-level transfer engine reports each byte that completes on the bus, the end of a transfer and protocol events, each as a one-cycle pulse. The block counts bytes against a configured buffer size of one to four locations. It raises the data flag when the last configured location has completed.

The data flag can be cleared in two ways, chosen by a control bit:
- Automatically, once software has accessed every configured buffer location.
- Only by an explicit software write.

Software can also set or clear any flag directly, which lets it pause or resume bus traffic on purpose.

Top module: `i2c_irq_hold_ctrl`

## Requirements
- R1: After reset all three flags are 0, `irq_data`, `irq_proto` and `scl_pull_low` are 0, and the byte index starts at location 0.
- R2: With `cfg_size_m1` = size minus one (0 to 3, meaning 1 to 4 locations), the data flag sets on the `ev_byte_done` pulse that completes location `cfg_size_m1`, and not on any earlier pulse.
- R3: `ev_byte_done` pulses are ignored while the data flag is set. When the data flag clears, the byte index restarts from location 0, so a full `cfg_size_m1`+1 pulses are needed again.
- R4: `ev_xfer_end` sets the end-of-transfer flag, and `ev_proto` sets the protocol-event flag.
- R5: An `ev_xfer_end` while `mode_slave_tx` is 1 and the data flag is clear also sets the data flag. In any other mode it leaves the data flag untouched.
- R6: `irq_data` equals data flag OR end-of-transfer flag, and `irq_proto` equals the protocol-event flag.
- R7: `scl_pull_low` is 1 exactly when at least one flag is set and (`mode_master` or `mode_slave_sel`) is 1. Otherwise it is 0, and it is 1 only as a pull-low request.
- R8: A software write applies `sw_flag_wdata[i]` to every flag whose `sw_flag_we[i]` is 1, and leaves the others alone. Bit 0 is the data flag, bit 1 the end-of-transfer flag and bit 2 the protocol-event flag.
- R9: With `cfg_sw_clear` = 0, the data flag clears at the edge on which the last still-missing location in 0..`cfg_size_m1` is accessed through `buf_acc_valid`/`buf_acc_idx`. Accesses may come in any order and may repeat. Locations above `cfg_size_m1` do not count.
- R10: With `cfg_sw_clear` = 1, buffer accesses never clear the data flag. Only a software write does.
- R11: When a hardware set event and a clear of the same flag (software or hardware) arrive at the same edge, the flag ends up set.
- R12: Each flag, and therefore every output, takes its new value at the clock edge that samples the causing input. Mode inputs affect `scl_pull_low` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size_m1 | input | 2 | Buffer size minus one |
| cfg_sw_clear | input | 1 | 1: data flag cleared by software only |
| mode_master | input | 1 | Peripheral is bus master |
| mode_slave_sel | input | 1 | Peripheral addressed as slave |
| mode_slave_tx | input | 1 | Peripheral is slave transmitter |
| ev_byte_done | input | 1 | Pulse: one buffer byte sent or received |
| ev_xfer_end | input | 1 | Pulse: transfer ended |
| ev_proto | input | 1 | Pulse: protocol event |
| buf_acc_valid | input | 1 | Software accessed a buffer location |
| buf_acc_idx | input | 2 | Location accessed |
| sw_flag_we | input | 3 | Per-flag software write enable |
| sw_flag_wdata | input | 3 | Per-flag software write value |
| irq_data | output | 1 | Data / end-of-transfer interrupt |
| irq_proto | output | 1 | Protocol-event interrupt |
| scl_pull_low | output | 1 | Request to pull SCL low |

## Verification
All flag changes are due one edge after the causing input is presented, and the outputs follow the flags without delay. The mode inputs change `scl_pull_low` in the cycle they are applied. Every scenario task therefore drives its inputs between edges, waits for one rising edge, and compares shortly after that edge. Checks that a mode change takes effect are made before the next edge. The data flag is hidden behind the OR on `irq_data`, so it is isolated by clearing the end-of-transfer flag alone through a masked software write.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLG_DATA  = 0;
  localparam int unsigned FLG_END   = 1;
  localparam int unsigned FLG_PROTO = 2;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;

  // width of a location index for a buffer of n locations
  function automatic int unsigned loc_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_buf_tracker.sv
module irq_buf_tracker #(
  parameter int unsigned LOCS  = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cfg_size_m1,
  input  logic             cfg_sw_clear,
  input  logic             mode_slave_tx,
  input  logic             ev_byte_done,
  input  logic             ev_xfer_end,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             d_now,
  input  logic             d_next,
  output logic             hw_set_d,
  output logic             hw_clr_d
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LOCS-1:0]  mask_q, mask_d;
  logic [LOCS-1:0]  need, acc_oh;
  logic             byte_take, last_byte, early_end, all_seen;

  // locations that a complete access must cover
  function automatic logic [LOCS-1:0] need_mask(input logic [IDX_W-1:0] m1);
    logic [LOCS-1:0] m;
    for (int i = 0; i < LOCS; i++) m[i] = (i <= int'(m1));
    return m;
  endfunction

  // one-hot of a counted access, zero when out of range
  function automatic logic [LOCS-1:0] access_bit(input logic v, input logic [IDX_W-1:0] ix,
                                                 input logic [IDX_W-1:0] m1);
    logic [LOCS-1:0] m;
    m = '0;
    if (v && (ix <= m1)) m[ix] = 1'b1;
    return m;
  endfunction

  always_comb begin
    need      = need_mask(cfg_size_m1);
    acc_oh    = access_bit(acc_valid, acc_idx, cfg_size_m1);
    byte_take = ev_byte_done & ~d_now;
    last_byte = byte_take & (idx_q == cfg_size_m1);
    early_end = ev_xfer_end & mode_slave_tx & ~d_now;
    hw_set_d  = last_byte | early_end;
    all_seen  = (((mask_q | acc_oh) & need) == need);
    hw_clr_d  = d_now & ~cfg_sw_clear & (|acc_oh) & all_seen;
  end

  always_comb begin
    idx_d = idx_q;
    if (d_now && !d_next)  idx_d = '0;
    else if (last_byte)    idx_d = '0;
    else if (byte_take)    idx_d = idx_q + IDX_W'(1);
    mask_d = (d_now && d_next) ? (mask_q | acc_oh) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mask_q <= '0;
    end else begin
      idx_q  <= idx_d;
      mask_q <= mask_d;
    end
  end

  // R9: a freshly set data flag starts with no locations accessed
  assert_mask_fresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(d_now) |-> (mask_q == '0));

  // R3: clearing the data flag sends the index home
  assert_idx_home_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (d_now && !d_next) |=> (idx_q == '0));

  // R10: in software-clear mode the tracker never requests a clear
  assert_no_hw_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sw_clear |-> !hw_clr_d);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import i2c_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t hw_set,
  input  flag_vec_t hw_clr,
  input  flag_vec_t sw_we,
  input  flag_vec_t sw_wdata,
  output flag_vec_t flags_q,
  output flag_vec_t flags_next
);
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    // hardware set has priority over every kind of clear
    always_comb begin
      if (hw_set[g])     flags_next[g] = 1'b1;
      else if (sw_we[g]) flags_next[g] = sw_wdata[g];
      else               flags_next[g] = flags_q[g] & ~hw_clr[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[g] <= 1'b0;
      else        flags_q[g] <= flags_next[g];
    end

    // R11: a set event always leaves the flag high
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set[g] |=> flags_q[g]);

    // R8: an idle flag with no write and no event keeps its value
    assert_flag_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_set[g] && !hw_clr[g] && !sw_we[g]) |=> $stable(flags_q[g]));
  end
endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive
  import i2c_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t flags,
  input  logic      mode_master,
  input  logic      mode_slave_sel,
  output logic      irq_data,
  output logic      irq_proto,
  output logic      scl_pull_low
);
  logic any_pending, bus_owned;

  always_comb begin
    any_pending  = |flags;
    bus_owned    = mode_master | mode_slave_sel;
    irq_data     = flags[FLG_DATA] | flags[FLG_END];
    irq_proto    = flags[FLG_PROTO];
    scl_pull_low = any_pending & bus_owned;
  end

  // R7: with nothing pending the line is always released
  assert_scl_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !scl_pull_low);

  // R7: an idle, unaddressed peripheral never stretches the clock
  assert_scl_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_master && !mode_slave_sel) |-> !scl_pull_low);

  // R6: the protocol line never shows the data-side flags
  assert_proto_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[FLG_PROTO] |-> !irq_proto);
endmodule

// File: rtl/i2c_irq_hold_ctrl.sv
module i2c_irq_hold_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int unsigned BUF_LOCS = 4,
  localparam int unsigned IDX_W   = loc_idx_w(BUF_LOCS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cfg_size_m1,
  input  logic             cfg_sw_clear,
  input  logic             mode_master,
  input  logic             mode_slave_sel,
  input  logic             mode_slave_tx,
  input  logic             ev_byte_done,
  input  logic             ev_xfer_end,
  input  logic             ev_proto,
  input  logic             buf_acc_valid,
  input  logic [IDX_W-1:0] buf_acc_idx,
  input  logic [2:0]       sw_flag_we,
  input  logic [2:0]       sw_flag_wdata,
  output logic             irq_data,
  output logic             irq_proto,
  output logic             scl_pull_low
);
  flag_vec_t flags_q, flags_next, hw_set, hw_clr;
  logic      hw_set_d, hw_clr_d;

  irq_buf_tracker #(.LOCS(BUF_LOCS), .IDX_W(IDX_W)) u_tracker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_size_m1   (cfg_size_m1),
    .cfg_sw_clear  (cfg_sw_clear),
    .mode_slave_tx (mode_slave_tx),
    .ev_byte_done  (ev_byte_done),
    .ev_xfer_end   (ev_xfer_end),
    .acc_valid     (buf_acc_valid),
    .acc_idx       (buf_acc_idx),
    .d_now         (flags_q[FLG_DATA]),
    .d_next        (flags_next[FLG_DATA]),
    .hw_set_d      (hw_set_d),
    .hw_clr_d      (hw_clr_d)
  );

  always_comb begin
    hw_set             = '0;
    hw_clr             = '0;
    hw_set[FLG_DATA]   = hw_set_d;
    hw_set[FLG_END]    = ev_xfer_end;
    hw_set[FLG_PROTO]  = ev_proto;
    hw_clr[FLG_DATA]   = hw_clr_d;
  end

  irq_flag_bank u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_set     (hw_set),
    .hw_clr     (hw_clr),
    .sw_we      (sw_flag_we),
    .sw_wdata   (sw_flag_wdata),
    .flags_q    (flags_q),
    .flags_next (flags_next)
  );

  irq_line_drive u_lines (
    .clk            (clk),
    .rst_n          (rst_n),
    .flags          (flags_q),
    .mode_master    (mode_master),
    .mode_slave_sel (mode_slave_sel),
    .irq_data       (irq_data),
    .irq_proto      (irq_proto),
    .scl_pull_low   (scl_pull_low)
  );

  // R10: software-clear mode keeps the data flag until software writes it
  assert_sw_only_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sw_clear && flags_q[FLG_DATA] && !sw_flag_we[FLG_DATA]) |=> flags_q[FLG_DATA]);

  // R4: a transfer end always reaches the data interrupt line
  assert_end_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer_end |=> irq_data);
endmodule

// File: tb/test_i2c_irq_hold_ctrl.sv
module test_i2c_irq_hold_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_size_m1 = 2'd0;
  logic       cfg_sw_clear = 1'b0;
  logic       mode_master = 1'b0, mode_slave_sel = 1'b0, mode_slave_tx = 1'b0;
  logic       ev_byte_done = 1'b0, ev_xfer_end = 1'b0, ev_proto = 1'b0;
  logic       buf_acc_valid = 1'b0;
  logic [1:0] buf_acc_idx = 2'd0;
  logic [2:0] sw_flag_we = 3'b0, sw_flag_wdata = 3'b0;
  logic       irq_data, irq_proto, scl_pull_low;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  i2c_irq_hold_ctrl i_i2c_irq_hold_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_size_m1(cfg_size_m1), .cfg_sw_clear(cfg_sw_clear),
    .mode_master(mode_master), .mode_slave_sel(mode_slave_sel), .mode_slave_tx(mode_slave_tx),
    .ev_byte_done(ev_byte_done), .ev_xfer_end(ev_xfer_end), .ev_proto(ev_proto),
    .buf_acc_valid(buf_acc_valid), .buf_acc_idx(buf_acc_idx),
    .sw_flag_we(sw_flag_we), .sw_flag_wdata(sw_flag_wdata),
    .irq_data(irq_data), .irq_proto(irq_proto), .scl_pull_low(scl_pull_low)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one rising edge, then clear all pulse inputs a moment later
  task automatic cyc();
    @(posedge clk);
    #1;
    ev_byte_done = 1'b0; ev_xfer_end = 1'b0; ev_proto = 1'b0;
    buf_acc_valid = 1'b0; sw_flag_we = 3'b0; sw_flag_wdata = 3'b0;
  endtask

  task automatic sw_write(input logic [2:0] we, input logic [2:0] wd);
    sw_flag_we = we; sw_flag_wdata = wd; cyc();
  endtask

  task automatic access(input logic [1:0] ix);
    buf_acc_valid = 1'b1; buf_acc_idx = ix; cyc();
  endtask

  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) begin ev_byte_done = 1'b1; cyc(); end
  endtask

  task automatic t_reset();
    check("R1 irq_data", irq_data, 1'b0);
    check("R1 irq_proto", irq_proto, 1'b0);
    check("R1 scl_pull_low", scl_pull_low, 1'b0);
  endtask

  task automatic t_fill(input logic [1:0] m1);
    cfg_size_m1 = m1; mode_master = 1'b1; cfg_sw_clear = 1'b1;
    bytes(int'(m1));
    check("R2 not yet full", irq_data, 1'b0);
    check("R7 no hold idle", scl_pull_low, 1'b0);
    bytes(1);
    check("R2 data flag at last location", irq_data, 1'b1);
    check("R7 hold while pending", scl_pull_low, 1'b1);
    sw_write(3'b001, 3'b000);
    check("R8 software clear data", irq_data, 1'b0);
    check("R7 release when clear", scl_pull_low, 1'b0);
  endtask

  task automatic t_ignore();
    cfg_size_m1 = 2'd1; cfg_sw_clear = 1'b1; mode_master = 1'b1;
    bytes(2);
    bytes(3);   // ignored while set
    sw_write(3'b001, 3'b000);
    bytes(1);
    check("R3 index restarted, one byte not enough", irq_data, 1'b0);
    bytes(1);
    check("R3 second byte completes", irq_data, 1'b1);
    sw_write(3'b001, 3'b000);
  endtask

  task automatic t_events();
    mode_master = 1'b0; mode_slave_tx = 1'b0;
    ev_xfer_end = 1'b1; cyc();
    check("R4 end flag", irq_data, 1'b1);
    check("R4 end not on proto", irq_proto, 1'b0);
    sw_write(3'b010, 3'b000);
    check("R5 no data flag outside slave tx", irq_data, 1'b0);
    ev_proto = 1'b1; cyc();
    check("R4 proto flag", irq_proto, 1'b1);
    check("R6 proto not on data line", irq_data, 1'b0);
    check("R7 no hold unaddressed", scl_pull_low, 1'b0);
    mode_slave_sel = 1'b1; #1;
    check("R12 addressed slave holds same cycle", scl_pull_low, 1'b1);
    mode_slave_sel = 1'b0;
    sw_write(3'b100, 3'b000);
    check("R8 software clear proto", irq_proto, 1'b0);
  endtask

  task automatic t_early_end();
    cfg_size_m1 = 2'd2; cfg_sw_clear = 1'b1;
    mode_slave_sel = 1'b1; mode_slave_tx = 1'b1;
    bytes(1);
    ev_xfer_end = 1'b1; cyc();
    sw_write(3'b010, 3'b000);
    check("R5 early end sets data flag", irq_data, 1'b1);
    check("R7 slave holds", scl_pull_low, 1'b1);
    sw_write(3'b001, 3'b000);
    mode_slave_tx = 1'b0;
    bytes(2);
    check("R3 index reset after clear", irq_data, 1'b0);
    bytes(1);
    check("R2 full after three", irq_data, 1'b1);
    sw_write(3'b001, 3'b000);
    mode_slave_sel = 1'b0;
  endtask

  task automatic t_auto_clear();
    cfg_size_m1 = 2'd2; cfg_sw_clear = 1'b0; mode_master = 1'b1;
    bytes(3);
    access(2'd3);
    access(2'd2);
    access(2'd0);
    access(2'd2);
    check("R9 not cleared with a location missing", irq_data, 1'b1);
    access(2'd1);
    check("R9 cleared on completing access", irq_data, 1'b0);
    check("R9 release after auto clear", scl_pull_low, 1'b0);
  endtask

  task automatic t_sw_mode();
    cfg_size_m1 = 2'd0; cfg_sw_clear = 1'b1; mode_master = 1'b1;
    bytes(1);
    for (int i = 0; i < 4; i++) access(2'(i));
    check("R10 accesses do not clear", irq_data, 1'b1);
    sw_write(3'b001, 3'b000);
    check("R10 software write clears", irq_data, 1'b0);
  endtask

  task automatic t_set_wins();
    mode_master = 1'b1;
    ev_xfer_end = 1'b1; sw_flag_we = 3'b010; sw_flag_wdata = 3'b000; cyc();
    check("R11 end set beats software clear", irq_data, 1'b1);
    sw_write(3'b010, 3'b000);
    cfg_size_m1 = 2'd0; cfg_sw_clear = 1'b1;
    ev_byte_done = 1'b1; sw_flag_we = 3'b001; sw_flag_wdata = 3'b000; cyc();
    check("R11 data set beats software clear", irq_data, 1'b1);
    sw_write(3'b111, 3'b100);
    check("R8 software set proto", irq_proto, 1'b1);
    check("R8 data cleared by same write", irq_data, 1'b0);
    sw_write(3'b100, 3'b000);
    check("R7 all clear releases", scl_pull_low, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_fill(2'd0);
    t_fill(2'd2);
    t_fill(2'd3);
    t_ignore();
    t_events();
    t_early_end();
    t_auto_clear();
    t_sw_mode();
    t_set_wins();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule